// File: doc/BRIEF.md
# Switch Matrix Scanner

This block reads a grid of switches. It drives one row line high at a time and reads the column sense lines back. It keeps the last known level of every switch in a state memory, and it records each difference as an event word in a small queue. The consuming logic sees the oldest event on `evt_data` while `evt_valid` is high, and it removes that event by pulsing `evt_pop`. `evt_valid` is also the not-empty flag that an interrupt controller can use.

The `large_mode` input picks the grid size. When it is 0 the block uses a 5x5 grid on rows 0-4 and columns 0-4. When it is 1 the block uses a 16x18 grid.

Raising `suspend_req` stops the scan. The block first wipes the state memory, then raises `idle` and parks the row lines in a wake-up pattern, so that a key press can still be seen while the chip sleeps. In the small grid, the parked pattern is either one selected row or all five rows. Dropping the request restarts the scan from row 0.

Top module: `sw_matrix_scan`

## Requirements
- R1: After reset, `row_drive` equals 0x0001 (row 0 only), `evt_valid` is 0 and `idle` is 0.
- R2: While scanning, exactly one row line is high. Rows are visited in ascending order and wrap to row 0 after the last row of the current grid. Each row stays high for `settle_cycles`+1 clocks before the columns are sampled, and then for one clock per column of the current grid.
- R3: With `large_mode`=0, only rows 0-4 are driven and only columns 0-4 are compared. A switch on column 5 or above produces no event.
- R4: With `large_mode`=1, all 16 rows are driven and all 18 columns are compared.
- R5: The event word is laid out as follows: bit 10 is 1 for pressed and 0 for released, bits 9:5 hold the row, and bits 4:0 hold the column. Each change of a switch yields exactly one event.
- R6: When several switches in one row change in the same scan, their events enter the queue in ascending column order.
- R7: The queue holds 16 events and is show-ahead: `evt_data` is the oldest entry, and `evt_valid` is high exactly when the queue is not empty. An event that arrives while the queue is full is dropped, and the state memory still records the new level, so the lost change is not reported later.
- R8: After `suspend_req` rises, every row line is low while the state memory is cleared, one row per clock for 16 clocks. `idle` then rises and stays high for as long as the request is held.
- R9: In suspend with the small grid, `park_single`=1 drives only row `park_row`, and a `park_row` above 4 selects row 0. `park_single`=0 drives rows 0-4 together (0x001F).
- R10: In suspend with the large grid, all 16 rows are driven (0xFFFF).
- R11: When `suspend_req` falls, `idle` goes low one clock later and the scan restarts at row 0. Because the state memory was cleared, a switch that is still held down is reported again as pressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| large_mode | input | 1 | Grid size select: 0 selects 5x5, 1 selects 16x18 |
| settle_cycles | input | 8 | Extra clocks a row is held before the columns are sampled |
| suspend_req | input | 1 | Request to enter suspend |
| park_single | input | 1 | Small-grid suspend: 1 parks on one row, 0 parks on all rows |
| park_row | input | 3 | Row used for a single-row park |
| col_sense | input | 18 | Column sense lines |
| row_drive | output | 16 | Row drive lines, active high |
| evt_valid | output | 1 | Queue not empty |
| evt_data | output | 11 | Oldest event: {pressed, row[4:0], col[4:0]} |
| evt_pop | input | 1 | Removes the oldest event |
| idle | output | 1 | Suspend entered and state memory cleared |

## Verification
If a state memory bit is wrong, the block shows it within one full scan, as an extra event or a missing event for that switch: at most 352 clocks in the large grid with a settle count of 3. If the row sequencer is wrong, `row_drive` shows it at once, as a non-one-hot pattern, a skipped row, or a wrong hold length on the first row after reset. A clear that never finishes shows up as `idle` staying low after the 16-clock wipe. A clear that is skipped shows up after resume, as a held key that produces no new press event.

// File: rtl/swscan_pkg.sv
package swscan_pkg;
   localparam int EVT_IDX_W = 5;

   typedef struct packed {
      logic                 pressed;
      logic [EVT_IDX_W-1:0] row;
      logic [EVT_IDX_W-1:0] col;
   } swscan_evt_t;

   typedef enum logic [1:0] {
      PH_SETTLE = 2'd0,
      PH_WALK   = 2'd1,
      PH_CLEAR  = 2'd2,
      PH_PARK   = 2'd3
   } swscan_phase_e;
endpackage

// File: rtl/swscan_state_mem.sv
module swscan_state_mem #(
   parameter int ROWS = 16,
   parameter int COLS = 18,
   localparam int ROW_W = $clog2(ROWS),
   localparam int COL_W = $clog2(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic [ROW_W-1:0] clr_row,
   input  logic             wr_en,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [COL_W-1:0] wr_col,
   input  logic             wr_val,
   input  logic [ROW_W-1:0] rd_row,
   input  logic [COL_W-1:0] rd_col,
   output logic             rd_val
);
   logic [COLS-1:0] level [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level[r] <= '0;
         end else if (clr_en && clr_row == ROW_W'(r)) begin
            level[r] <= '0;
         end else if (wr_en && wr_row == ROW_W'(r)) begin
            level[r][wr_col] <= wr_val;
         end
      end
   end

   assign rd_val = level[rd_row][rd_col];
endmodule

// File: rtl/swscan_evt_fifo.sv
module swscan_evt_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 11,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   logic [WIDTH-1:0] slot [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [AW:0]      fill;
   logic             wr_ok, rd_ok;

   assign empty = (fill == '0);
   assign full  = (fill == (AW+1)'(DEPTH));
   assign wr_ok = push && !full;
   assign rd_ok = pop && !empty;
   assign dout  = slot[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_ok) slot[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/swscan_park.sv
module swscan_park #(
   parameter int ROWS       = 16,
   parameter int SMALL_ROWS = 5,
   parameter int PARK_ROW_W = 3
) (
   input  logic                  large_mode,
   input  logic                  park_single,
   input  logic [PARK_ROW_W-1:0] park_row,
   output logic [ROWS-1:0]       pattern
);
   logic [PARK_ROW_W-1:0] sel;

   assign sel = (park_row < PARK_ROW_W'(SMALL_ROWS)) ? park_row : '0;

   for (genvar r = 0; r < ROWS; r++) begin : g_bit
      if (r < SMALL_ROWS) begin : g_small
         assign pattern[r] = large_mode || !park_single || (sel == PARK_ROW_W'(r));
      end else begin : g_big
         assign pattern[r] = large_mode;
      end
   end
endmodule

// File: rtl/swscan_seq.sv
module swscan_seq
   import swscan_pkg::*;
#(
   parameter int ROWS       = 16,
   parameter int COLS       = 18,
   parameter int SMALL_ROWS = 5,
   parameter int SMALL_COLS = 5,
   parameter int SETTLE_W   = 8,
   localparam int ROW_W = $clog2(ROWS),
   localparam int COL_W = $clog2(COLS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                large_mode,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic                suspend_req,
   input  logic [COLS-1:0]     col_sense,
   input  logic                rd_val,
   output swscan_phase_e       phase,
   output logic [ROW_W-1:0]    row_idx,
   output logic [COL_W-1:0]    col_idx,
   output logic                clr_en,
   output logic [ROW_W-1:0]    clr_row,
   output logic                push,
   output swscan_evt_t         push_evt
);
   logic [SETTLE_W-1:0] hold_cnt;
   logic [COLS-1:0]     snap;
   logic [ROW_W-1:0]    last_row;
   logic [COL_W-1:0]    last_col;
   logic                at_last_col;

   assign last_row    = large_mode ? ROW_W'(ROWS-1) : ROW_W'(SMALL_ROWS-1);
   assign last_col    = large_mode ? COL_W'(COLS-1) : COL_W'(SMALL_COLS-1);
   assign at_last_col = (col_idx >= last_col);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_SETTLE;
         row_idx  <= '0;
         col_idx  <= '0;
         hold_cnt <= '0;
         clr_row  <= '0;
         snap     <= '0;
      end else begin
         unique case (phase)
            PH_SETTLE: begin
               if (suspend_req) begin
                  phase   <= PH_CLEAR;
                  clr_row <= '0;
               end else if (hold_cnt >= settle_cycles) begin
                  snap    <= col_sense;
                  col_idx <= '0;
                  phase   <= PH_WALK;
               end else begin
                  hold_cnt <= hold_cnt + 1'b1;
               end
            end
            PH_WALK: begin
               if (suspend_req) begin
                  phase   <= PH_CLEAR;
                  clr_row <= '0;
               end else if (at_last_col) begin
                  col_idx  <= '0;
                  hold_cnt <= '0;
                  row_idx  <= (row_idx >= last_row) ? '0 : row_idx + 1'b1;
                  phase    <= PH_SETTLE;
               end else begin
                  col_idx <= col_idx + 1'b1;
               end
            end
            PH_CLEAR: begin
               clr_row <= clr_row + 1'b1;
               if (clr_row == ROW_W'(ROWS-1)) begin
                  phase    <= suspend_req ? PH_PARK : PH_SETTLE;
                  row_idx  <= '0;
                  col_idx  <= '0;
                  hold_cnt <= '0;
               end
            end
            PH_PARK: begin
               if (!suspend_req) begin
                  phase    <= PH_SETTLE;
                  row_idx  <= '0;
                  col_idx  <= '0;
                  hold_cnt <= '0;
               end
            end
            default: phase <= PH_SETTLE;
         endcase
      end
   end

   assign clr_en           = (phase == PH_CLEAR);
   assign push             = (phase == PH_WALK) && !suspend_req && (snap[col_idx] != rd_val);
   assign push_evt.pressed = snap[col_idx];
   assign push_evt.row     = EVT_IDX_W'(row_idx);
   assign push_evt.col     = EVT_IDX_W'(col_idx);
endmodule

// File: rtl/sw_matrix_scan.sv
module sw_matrix_scan
   import swscan_pkg::*;
#(
   parameter int ROWS       = 16,
   parameter int COLS       = 18,
   parameter int SMALL_ROWS = 5,
   parameter int SMALL_COLS = 5,
   parameter int FIFO_DEPTH = 16,
   parameter int SETTLE_W   = 8,
   parameter int PARK_ROW_W = 3,
   localparam int ROW_W = $clog2(ROWS),
   localparam int COL_W = $clog2(COLS),
   localparam int EVT_W = $bits(swscan_evt_t)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  large_mode,
   input  logic [SETTLE_W-1:0]   settle_cycles,
   input  logic                  suspend_req,
   input  logic                  park_single,
   input  logic [PARK_ROW_W-1:0] park_row,
   input  logic [COLS-1:0]       col_sense,
   output logic [ROWS-1:0]       row_drive,
   output logic                  evt_valid,
   output logic [EVT_W-1:0]      evt_data,
   input  logic                  evt_pop,
   output logic                  idle
);
   if (ROWS > (1 << EVT_IDX_W) || COLS > (1 << EVT_IDX_W)) begin : g_bad_dim
      $error("grid exceeds event index width");
   end
   if (SMALL_ROWS > ROWS || SMALL_COLS > COLS || SMALL_ROWS < 1 || SMALL_COLS < 1) begin : g_bad_small
      $error("small grid must fit inside the large grid");
   end
   if (SMALL_ROWS > (1 << PARK_ROW_W)) begin : g_bad_park
      $error("park row select too narrow");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_fifo
      $error("queue depth must be a power of two");
   end

   swscan_phase_e    phase;
   logic [ROW_W-1:0] row_idx, clr_row;
   logic [COL_W-1:0] col_idx;
   logic             clr_en, push, rd_val, fifo_empty, fifo_full;
   logic             scan_active;
   swscan_evt_t      push_evt;
   logic [ROWS-1:0]  park_pattern, scan_pattern;

   swscan_seq #(
      .ROWS(ROWS), .COLS(COLS), .SMALL_ROWS(SMALL_ROWS),
      .SMALL_COLS(SMALL_COLS), .SETTLE_W(SETTLE_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .large_mode(large_mode),
      .settle_cycles(settle_cycles), .suspend_req(suspend_req),
      .col_sense(col_sense), .rd_val(rd_val), .phase(phase),
      .row_idx(row_idx), .col_idx(col_idx), .clr_en(clr_en),
      .clr_row(clr_row), .push(push), .push_evt(push_evt)
   );

   swscan_state_mem #(.ROWS(ROWS), .COLS(COLS)) u_mem (
      .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .clr_row(clr_row),
      .wr_en(push), .wr_row(row_idx), .wr_col(col_idx),
      .wr_val(push_evt.pressed), .rd_row(row_idx), .rd_col(col_idx),
      .rd_val(rd_val)
   );

   swscan_evt_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(EVT_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(push_evt),
      .pop(evt_pop), .dout(evt_data), .empty(fifo_empty), .full(fifo_full)
   );

   swscan_park #(
      .ROWS(ROWS), .SMALL_ROWS(SMALL_ROWS), .PARK_ROW_W(PARK_ROW_W)
   ) u_park (
      .large_mode(large_mode), .park_single(park_single),
      .park_row(park_row), .pattern(park_pattern)
   );

   for (genvar r = 0; r < ROWS; r++) begin : g_dec
      assign scan_pattern[r] = (row_idx == ROW_W'(r));
   end

   assign scan_active = (phase == PH_SETTLE) || (phase == PH_WALK);
   assign idle        = (phase == PH_PARK);
   assign evt_valid   = !fifo_empty;

   always_comb begin
      unique case (phase)
         PH_SETTLE, PH_WALK: row_drive = scan_pattern;
         PH_PARK:            row_drive = park_pattern;
         default:            row_drive = '0;
      endcase
   end
endmodule

// File: rtl/swscan_checker.sv
module swscan_checker #(
   parameter int ROWS       = 16,
   parameter int PARK_ROW_W = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  suspend_req,
   input logic                  large_mode,
   input logic                  park_single,
   input logic [PARK_ROW_W-1:0] park_row,
   input logic [ROWS-1:0]       row_drive,
   input logic                  idle,
   input logic                  evt_valid,
   input logic                  scan_active,
   input logic                  push
);
   a_r2_single_row_scan: assert property (@(posedge clk) disable iff (!rst_n)
      scan_active |-> $onehot(row_drive));

   a_r7_push_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> evt_valid);

   a_r8_rows_quiet_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (suspend_req && !scan_active && !idle) |-> (row_drive == '0));

   a_r11_idle_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> $past(suspend_req));

   a_r11_resume_row0: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle) |-> (row_drive == ROWS'(1)));

   a_r10_large_park_all: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && large_mode) |-> (&row_drive));

   a_r9_park_single: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !large_mode && park_single) |-> $onehot(row_drive));
endmodule

bind sw_matrix_scan swscan_checker #(.ROWS(ROWS), .PARK_ROW_W(PARK_ROW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req), .large_mode(large_mode),
   .park_single(park_single), .park_row(park_row), .row_drive(row_drive),
   .idle(idle), .evt_valid(evt_valid), .scan_active(scan_active), .push(push)
);

// File: tb/sw_matrix_scan_test.sv
module sw_matrix_scan_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        large_mode = 1'b0;
   logic [7:0]  settle_cycles = 8'd3;
   logic        suspend_req = 1'b0;
   logic        park_single = 1'b1;
   logic [2:0]  park_row = 3'd0;
   logic [17:0] col_sense;
   logic [15:0] row_drive;
   logic        evt_valid;
   logic [10:0] evt_data;
   logic        evt_pop = 1'b0;
   logic        idle;

   logic [17:0] pressed [16];
   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      col_sense = '0;
      for (int r = 0; r < 16; r++) if (row_drive[r]) col_sense |= pressed[r];
   end

   sw_matrix_scan uut (
      .clk(clk), .rst_n(rst_n), .large_mode(large_mode),
      .settle_cycles(settle_cycles), .suspend_req(suspend_req),
      .park_single(park_single), .park_row(park_row), .col_sense(col_sense),
      .row_drive(row_drive), .evt_valid(evt_valid), .evt_data(evt_data),
      .evt_pop(evt_pop), .idle(idle)
   );

   function automatic logic [10:0] ev(input bit p, input int r, input int c);
      return {p, 5'(r), 5'(c)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pop_evt(output bit got, output logic [10:0] d);
      @(negedge clk);
      got = evt_valid;
      d   = evt_data;
      if (got) begin
         evt_pop = 1'b1;
         @(negedge clk);
         evt_pop = 1'b0;
      end
   endtask

   task automatic drain(output int n);
      bit got;
      logic [10:0] d;
      n = 0;
      do begin
         pop_evt(got, d);
         if (got) n++;
      end while (got);
   endtask

   task automatic expect_evt(input logic [10:0] exp, input string req);
      bit got;
      logic [10:0] d;
      pop_evt(got, d);
      chk(got, {req, " event present"}, 32'(got), 32'd1);
      chk(d == exp, {req, " event word"}, 32'(d), 32'(exp));
   endtask

   task automatic t_reset;
      for (int r = 0; r < 16; r++) pressed[r] = '0;
      rst_n = 1'b0;
      cycles(3);
      chk(row_drive == 16'h0001, "R1 row_drive", 32'(row_drive), 32'h1);
      chk(!evt_valid, "R1 evt_valid", 32'(evt_valid), 32'd0);
      chk(!idle, "R1 idle", 32'(idle), 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_scan_timing;
      int n = 0;
      while (row_drive == 16'h0001 && n < 50) begin
         n++;
         @(negedge clk);
      end
      chk(n == 9, "R2 row0 hold 4 settle + 5 cols", 32'(n), 32'd9);
      chk(row_drive == 16'h0002, "R2 ascending next row", 32'(row_drive), 32'h2);
      n = 0;
      while (row_drive != 16'h0010 && n < 100) begin n++; @(negedge clk); end
      while (row_drive == 16'h0010 && n < 200) begin n++; @(negedge clk); end
      chk(row_drive == 16'h0001, "R2 wrap after row 4 in small grid", 32'(row_drive), 32'h1);
   endtask

   task automatic t_small_press;
      int n;
      pressed[2][3] = 1'b1;
      cycles(120);
      expect_evt(ev(1, 2, 3), "R5 press");
      pressed[2][3] = 1'b0;
      cycles(120);
      expect_evt(ev(0, 2, 3), "R5 release");
      drain(n);
      chk(n == 0, "R5 one event per change", 32'(n), 32'd0);
      pressed[1][6] = 1'b1;
      pressed[7][1] = 1'b1;
      cycles(200);
      chk(!evt_valid, "R3 column 6 and row 7 ignored in small grid", 32'(evt_valid), 32'd0);
      pressed[1][6] = 1'b0;
      pressed[7][1] = 1'b0;
   endtask

   task automatic t_row_order;
      int n;
      pressed[4][4] = 1'b1;
      pressed[4][0] = 1'b1;
      pressed[4][2] = 1'b1;
      cycles(120);
      expect_evt(ev(1, 4, 0), "R6 first col 0");
      expect_evt(ev(1, 4, 2), "R6 then col 2");
      expect_evt(ev(1, 4, 4), "R6 then col 4");
      pressed[4] = '0;
      cycles(120);
      drain(n);
      chk(n == 3, "R6 releases", 32'(n), 32'd3);
   endtask

   task automatic t_large;
      int n;
      large_mode = 1'b1;
      pressed[15][17] = 1'b1;
      cycles(800);
      expect_evt(ev(1, 15, 17), "R4 far corner press");
      drain(n);
      chk(n == 0, "R4 single event", 32'(n), 32'd0);
      pressed[15][17] = 1'b0;
      cycles(800);
      expect_evt(ev(0, 15, 17), "R4 far corner release");
   endtask

   task automatic t_overflow;
      int n = 0;
      bit got;
      logic [10:0] d;
      pressed[7] = '1;
      cycles(800);
      chk(evt_valid, "R7 valid while not empty", 32'(evt_valid), 32'd1);
      do begin
         pop_evt(got, d);
         if (got) begin
            chk(d == ev(1, 7, n), "R7 kept entries in order", 32'(d), 32'(ev(1, 7, n)));
            n++;
         end
      end while (got);
      chk(n == 16, "R7 queue holds 16, rest dropped", 32'(n), 32'd16);
      cycles(800);
      chk(!evt_valid, "R7 dropped changes not reported later", 32'(evt_valid), 32'd0);
      pressed[7] = '0;
      cycles(800);
      drain(n);
      chk(n == 16, "R7 release burst also capped", 32'(n), 32'd16);
   endtask

   task automatic t_suspend_small;
      int n;
      large_mode = 1'b0;
      cycles(400);
      drain(n);
      pressed[1][1] = 1'b1;
      cycles(120);
      expect_evt(ev(1, 1, 1), "R11 setup press");
      park_single = 1'b1;
      park_row    = 3'd3;
      suspend_req = 1'b1;
      cycles(3);
      chk(row_drive == 16'h0, "R8 rows low while clearing", 32'(row_drive), 32'h0);
      chk(!idle, "R8 idle low while clearing", 32'(idle), 32'd0);
      cycles(20);
      chk(idle, "R8 idle after clear", 32'(idle), 32'd1);
      chk(row_drive == 16'h0008, "R9 park on row 3", 32'(row_drive), 32'h8);
      park_row = 3'd6;
      #1;
      chk(row_drive == 16'h0001, "R9 row above 4 parks on row 0", 32'(row_drive), 32'h1);
      park_single = 1'b0;
      #1;
      chk(row_drive == 16'h001F, "R9 all small rows", 32'(row_drive), 32'h1F);
      cycles(50);
      chk(idle, "R8 idle held", 32'(idle), 32'd1);
      suspend_req = 1'b0;
      @(negedge clk);
      chk(!idle, "R11 idle falls", 32'(idle), 32'd0);
      chk(row_drive == 16'h0001, "R11 restart at row 0", 32'(row_drive), 32'h1);
      cycles(120);
      expect_evt(ev(1, 1, 1), "R11 held key reported again");
      pressed[1][1] = 1'b0;
      cycles(120);
      drain(n);
   endtask

   task automatic t_suspend_large;
      large_mode  = 1'b1;
      park_single = 1'b1;
      suspend_req = 1'b1;
      cycles(25);
      chk(idle, "R10 idle in large grid", 32'(idle), 32'd1);
      chk(row_drive == 16'hFFFF, "R10 all rows parked", 32'(row_drive), 32'hFFFF);
      suspend_req = 1'b0;
      @(negedge clk);
      chk(row_drive == 16'h0001, "R11 large restart at row 0", 32'(row_drive), 32'h1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_reset;
      t_scan_timing;
      t_small_press;
      t_row_order;
      t_large;
      t_overflow;
      t_suspend_small;
      t_suspend_large;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule